// File: doc/BRIEF.md
# Early Index Look-up Coordinator

This controller sits in front of one cache bank that receives each read twice: first its set index alone, over a narrow low-latency path, and some cycles later the complete address, tag included, over a wider but slower path. It launches the set read as soon as an index arrives. The bank then advances to its tag-compare stage, where it holds until the complete address catches up.

When the complete address arrives, the controller compares it with the index it is holding. If the two agree and the request is a read, the controller releases tag comparison using the arriving tag. If they disagree, or the request is a write, the controller cancels the speculative look-up and starts a fresh set read from the complete address.

Only one speculative look-up can be open at a time. Further early indices wait in a small queue, and the queue pushes back on the early path when it is full. A complete address that arrives while nothing speculative is open starts an ordinary access in the same cycle. The early path carries no error protection, because a wrong index only costs a restart.

Top module: `early_lookup_ctrl`

## Requirements
- R1: After reset, no set read, tag compare, squash or stall is signalled, and both `early_ready_o` and `full_ready_o` are high.
- R2: An early index accepted in cycle t with the controller idle and its queue empty produces `set_read_o` with `set_idx_o` equal to that index in cycle t+1.
- R3: Once the set read for an open early look-up has completed (`set_done_i`), `stall_o` is high from the next cycle on, and `tag_cmp_o` stays low until a matching complete address is accepted.
- R4: A complete read address whose index equals the held index gives no squash and no new set read. If the set read has already completed, `tag_cmp_o` is high in the following cycle, with `cmp_tag_o`/`cmp_idx_o` equal to the arriving address and `cmp_write_o` = 0.
- R5: A complete address whose index differs from the held index raises `squash_o` and `set_read_o` in its arrival cycle, with `set_idx_o` equal to the new index. Tag compare for the new access waits for a fresh `set_done_i`.
- R6: A write (`full_write_i` = 1) never uses a speculative read. It always starts its own set read in its arrival cycle, squashing an open early look-up even when the index matches, and its tag compare shows `cmp_write_o` = 1.
- R7: While a look-up is open, further early indices are queued and start no set read.
- R8: With `FIFO_DEPTH` indices queued, `early_ready_o` is low, and an index offered in that state is dropped and never started.
- R9: A complete address that arrives while idle with nothing queued starts a set read on its own index in the same cycle, with no squash.
- R10: A complete address that arrives while idle, when the oldest queued early index equals its index and it is a read, removes that queued entry, so the index is not read a second time.
- R11: `full_ready_o` is low from the cycle after a complete address is accepted until tag compare is signalled.
- R12: Queued early indices start in arrival order, each one cycle after the previous look-up's tag compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| early_valid_i | input | 1 | Early index offered |
| early_idx_i | input | IDX_W | Early set index |
| early_ready_o | output | 1 | Early queue can accept |
| full_valid_i | input | 1 | Complete address offered |
| full_idx_i | input | IDX_W | Complete address, index field |
| full_tag_i | input | TAG_W | Complete address, tag field |
| full_write_i | input | 1 | 1 = write, 0 = read |
| full_ready_o | output | 1 | Complete address can be accepted |
| set_done_i | input | 1 | Bank reports set read reached tag-compare stage |
| set_read_o | output | 1 | Start a set read |
| set_idx_o | output | IDX_W | Index for the set read |
| tag_cmp_o | output | 1 | Release tag comparison |
| cmp_idx_o | output | IDX_W | Index of the compared access |
| cmp_tag_o | output | TAG_W | Tag to compare |
| cmp_write_o | output | 1 | Compared access is a write |
| squash_o | output | 1 | Cancel the open early look-up |
| stall_o | output | 1 | Bank held at tag-compare stage |

## Verification
Two coincidences matter most. In the first, the queue takes a new early index in the same cycle that it hands its head to a starting look-up. The bench provokes this by offering indices back to back while the controller is idle, and judges it by whether the start order and the back-pressure point both come out as expected. In the second, a mismatching complete address squashes a look-up and restarts it in one cycle. Here the bench checks that the restart index is the new one and that tag compare does not fire until a fresh completion is reported.

// File: rtl/elu_pkg.sv
package elu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EARLY = 2'd1,
    ST_WAIT  = 2'd2
  } elu_state_e;
endpackage

// File: rtl/elu_fifo.sv
module elu_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign head_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= push_data_i;
  end
endmodule

// File: rtl/elu_match.sv
module elu_match #(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] ref_idx_i,
  input  logic [IDX_W-1:0] new_idx_i,
  input  logic             new_write_i,
  output logic             hit_o
);
  // writes never reuse a speculative read
  assign hit_o = !new_write_i && (ref_idx_i == new_idx_i);
endmodule

// File: rtl/elu_seq.sv
module elu_seq
  import elu_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int TAG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             q_empty_i,
  input  logic [IDX_W-1:0] q_head_i,
  input  logic             head_hit_i,
  input  logic             held_hit_i,
  input  logic             full_valid_i,
  input  logic [IDX_W-1:0] full_idx_i,
  input  logic [TAG_W-1:0] full_tag_i,
  input  logic             full_write_i,
  input  logic             set_done_i,
  output logic             q_pop_o,
  output logic [IDX_W-1:0] held_idx_o,
  output logic             full_ready_o,
  output logic             set_read_o,
  output logic [IDX_W-1:0] set_idx_o,
  output logic             tag_cmp_o,
  output logic [IDX_W-1:0] cmp_idx_o,
  output logic [TAG_W-1:0] cmp_tag_o,
  output logic             cmp_write_o,
  output logic             squash_o,
  output logic             stall_o
);
  elu_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;
  logic             wr_q;
  logic             set_rdy_q;
  logic             take_full;

  assign full_ready_o = (st_q != ST_WAIT);
  assign take_full    = full_valid_i && full_ready_o;
  assign held_idx_o   = idx_q;
  assign cmp_idx_o    = idx_q;
  assign cmp_tag_o    = tag_q;
  assign cmp_write_o  = wr_q;
  assign stall_o      = (st_q == ST_EARLY) && set_rdy_q;

  always_comb begin
    st_d       = st_q;
    q_pop_o    = 1'b0;
    set_read_o = 1'b0;
    set_idx_o  = full_idx_i;
    tag_cmp_o  = 1'b0;
    squash_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (full_valid_i) begin
          set_read_o = 1'b1;
          q_pop_o    = !q_empty_i && head_hit_i;
          st_d       = ST_WAIT;
        end else if (!q_empty_i) begin
          set_read_o = 1'b1;
          set_idx_o  = q_head_i;
          q_pop_o    = 1'b1;
          st_d       = ST_EARLY;
        end
      end
      ST_EARLY: begin
        if (full_valid_i) begin
          st_d = ST_WAIT;
          if (!held_hit_i) begin
            squash_o   = 1'b1;
            set_read_o = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        tag_cmp_o = set_rdy_q || set_done_i;
        if (tag_cmp_o) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      tag_q     <= '0;
      wr_q      <= 1'b0;
      set_rdy_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (set_read_o)      set_rdy_q <= 1'b0;
      else if (tag_cmp_o)  set_rdy_q <= 1'b0;
      else if (set_done_i) set_rdy_q <= 1'b1;
      if (take_full) begin
        idx_q <= full_idx_i;
        tag_q <= full_tag_i;
        wr_q  <= full_write_i;
      end else if (st_q == ST_IDLE && !q_empty_i) begin
        idx_q <= q_head_i;
        wr_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/early_lookup_ctrl.sv
module early_lookup_ctrl #(
  parameter int IDX_W      = 10,
  parameter int TAG_W      = 16,
  parameter int FIFO_DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             early_valid_i,
  input  logic [IDX_W-1:0] early_idx_i,
  output logic             early_ready_o,
  input  logic             full_valid_i,
  input  logic [IDX_W-1:0] full_idx_i,
  input  logic [TAG_W-1:0] full_tag_i,
  input  logic             full_write_i,
  output logic             full_ready_o,
  input  logic             set_done_i,
  output logic             set_read_o,
  output logic [IDX_W-1:0] set_idx_o,
  output logic             tag_cmp_o,
  output logic [IDX_W-1:0] cmp_idx_o,
  output logic [TAG_W-1:0] cmp_tag_o,
  output logic             cmp_write_o,
  output logic             squash_o,
  output logic             stall_o
);
  logic             q_empty, q_full, q_pop;
  logic [IDX_W-1:0] q_head, held_idx;
  logic             head_hit, held_hit;

  assign early_ready_o = !q_full;

  elu_fifo #(.W(IDX_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (early_valid_i),
    .push_data_i (early_idx_i),
    .pop_i       (q_pop),
    .head_o      (q_head),
    .empty_o     (q_empty),
    .full_o      (q_full)
  );

  elu_match #(.IDX_W(IDX_W)) i_match_held (
    .ref_idx_i   (held_idx),
    .new_idx_i   (full_idx_i),
    .new_write_i (full_write_i),
    .hit_o       (held_hit)
  );

  elu_match #(.IDX_W(IDX_W)) i_match_head (
    .ref_idx_i   (q_head),
    .new_idx_i   (full_idx_i),
    .new_write_i (full_write_i),
    .hit_o       (head_hit)
  );

  elu_seq #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .q_empty_i    (q_empty),
    .q_head_i     (q_head),
    .head_hit_i   (head_hit),
    .held_hit_i   (held_hit),
    .full_valid_i (full_valid_i),
    .full_idx_i   (full_idx_i),
    .full_tag_i   (full_tag_i),
    .full_write_i (full_write_i),
    .set_done_i   (set_done_i),
    .q_pop_o      (q_pop),
    .held_idx_o   (held_idx),
    .full_ready_o (full_ready_o),
    .set_read_o   (set_read_o),
    .set_idx_o    (set_idx_o),
    .tag_cmp_o    (tag_cmp_o),
    .cmp_idx_o    (cmp_idx_o),
    .cmp_tag_o    (cmp_tag_o),
    .cmp_write_o  (cmp_write_o),
    .squash_o     (squash_o),
    .stall_o      (stall_o)
  );
endmodule

// File: rtl/early_lookup_ctrl_chk.sv
module early_lookup_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic full_valid_i,
  input logic full_write_i,
  input logic full_ready_o,
  input logic set_read_o,
  input logic tag_cmp_o,
  input logic squash_o,
  input logic stall_o
);
  assert_stall_blocks_cmp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !tag_cmp_o);
  assert_squash_restarts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> set_read_o && full_valid_i);
  assert_write_own_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_valid_i && full_write_i && full_ready_o |-> set_read_o);
  assert_single_open_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_read_o |-> full_ready_o);
  assert_busy_during_cmp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_cmp_o |-> !full_ready_o);
  assert_cmp_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_cmp_o |=> !tag_cmp_o);
endmodule

bind early_lookup_ctrl early_lookup_ctrl_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .full_valid_i (full_valid_i),
  .full_write_i (full_write_i),
  .full_ready_o (full_ready_o),
  .set_read_o   (set_read_o),
  .tag_cmp_o    (tag_cmp_o),
  .squash_o     (squash_o),
  .stall_o      (stall_o)
);

// File: tb/test_early_lookup_ctrl.sv
`timescale 1ns/1ps
module test_early_lookup_ctrl;
  localparam int IDX_W = 10;
  localparam int TAG_W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic early_valid_i = 1'b0;
  logic [IDX_W-1:0] early_idx_i = '0;
  logic full_valid_i = 1'b0;
  logic [IDX_W-1:0] full_idx_i = '0;
  logic [TAG_W-1:0] full_tag_i = '0;
  logic full_write_i = 1'b0;
  logic set_done_i = 1'b0;
  logic early_ready_o, full_ready_o, set_read_o, tag_cmp_o, cmp_write_o, squash_o, stall_o;
  logic [IDX_W-1:0] set_idx_o, cmp_idx_o;
  logic [TAG_W-1:0] cmp_tag_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  early_lookup_ctrl i_early_lookup_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    settle();
    chk("R1 set_read", set_read_o, 0);
    chk("R1 tag_cmp", tag_cmp_o, 0);
    chk("R1 squash", squash_o, 0);
    chk("R1 stall", stall_o, 0);
    chk("R1 early_ready", early_ready_o, 1);
    chk("R1 full_ready", full_ready_o, 1);
  endtask

  task automatic t_early_match();
    early_valid_i = 1; early_idx_i = 10'd5;
    tick(); early_valid_i = 0; settle();
    chk("R2 set_read", set_read_o, 1);
    chk("R2 set_idx", set_idx_o, 5);
    tick(); set_done_i = 1; settle();
    chk("R3 stall before done", stall_o, 0);
    tick(); set_done_i = 0; settle();
    chk("R3 stall", stall_o, 1);
    chk("R3 no cmp", tag_cmp_o, 0);
    tick(); settle();
    chk("R3 stall hold", stall_o, 1);
    full_valid_i = 1; full_idx_i = 10'd5; full_tag_i = 16'h1234; full_write_i = 0; settle();
    chk("R4 no squash", squash_o, 0);
    chk("R4 no reread", set_read_o, 0);
    tick(); full_valid_i = 0; settle();
    chk("R4 cmp", tag_cmp_o, 1);
    chk("R4 tag", cmp_tag_o, 16'h1234);
    chk("R4 idx", cmp_idx_o, 5);
    chk("R4 write", cmp_write_o, 0);
    chk("R11 busy", full_ready_o, 0);
    tick(); settle();
    chk("R4 cmp once", tag_cmp_o, 0);
  endtask

  task automatic t_mismatch();
    early_valid_i = 1; early_idx_i = 10'd7;
    tick(); early_valid_i = 0;
    tick();
    full_valid_i = 1; full_idx_i = 10'd9; full_tag_i = 16'h0055; full_write_i = 0; settle();
    chk("R5 squash", squash_o, 1);
    chk("R5 restart", set_read_o, 1);
    chk("R5 restart idx", set_idx_o, 9);
    tick(); full_valid_i = 0; settle();
    chk("R5 wait fresh done", tag_cmp_o, 0);
    set_done_i = 1; settle();
    chk("R5 cmp", tag_cmp_o, 1);
    chk("R5 cmp idx", cmp_idx_o, 9);
    chk("R5 cmp tag", cmp_tag_o, 16'h0055);
    tick(); set_done_i = 0;
  endtask

  task automatic t_write();
    early_valid_i = 1; early_idx_i = 10'd3;
    tick(); early_valid_i = 0;
    tick();
    full_valid_i = 1; full_idx_i = 10'd3; full_tag_i = 16'h0077; full_write_i = 1; settle();
    chk("R6 squash same idx", squash_o, 1);
    chk("R6 own read", set_read_o, 1);
    tick(); full_valid_i = 0; full_write_i = 0; set_done_i = 1; settle();
    chk("R6 cmp", tag_cmp_o, 1);
    chk("R6 cmp write", cmp_write_o, 1);
    tick(); set_done_i = 0;
    full_valid_i = 1; full_idx_i = 10'd4; full_tag_i = 16'h0044; full_write_i = 1; settle();
    chk("R9 idle start", set_read_o, 1);
    chk("R9 idle idx", set_idx_o, 4);
    chk("R9 no squash", squash_o, 0);
    tick(); full_valid_i = 0; full_write_i = 0; set_done_i = 1; settle();
    chk("R6 idle write cmp", cmp_write_o, 1);
    tick(); set_done_i = 0;
  endtask

  task automatic t_queue();
    early_valid_i = 1; early_idx_i = 10'd1;
    tick(); early_idx_i = 10'd2; settle();
    chk("R2 start head", set_idx_o, 1);
    tick(); early_idx_i = 10'd3;
    tick(); early_idx_i = 10'd8; settle();
    chk("R8 backpressure", early_ready_o, 0);
    chk("R7 no second start", set_read_o, 0);
    tick(); early_valid_i = 0;
    full_valid_i = 1; full_idx_i = 10'd1; full_tag_i = 16'h000A; set_done_i = 1;
    tick(); full_valid_i = 0; set_done_i = 0; settle();
    chk("R4 cmp q1", tag_cmp_o, 1);
    tick(); settle();
    chk("R12 next start", set_read_o, 1);
    chk("R12 order 2", set_idx_o, 2);
    tick(); full_valid_i = 1; full_idx_i = 10'd2; set_done_i = 1;
    tick(); full_valid_i = 0; set_done_i = 0;
    tick(); settle();
    chk("R12 order 3", set_idx_o, 3);
    chk("R12 start 3", set_read_o, 1);
    tick(); full_valid_i = 1; full_idx_i = 10'd3; set_done_i = 1;
    tick(); full_valid_i = 0; set_done_i = 0;
    tick(); settle();
    chk("R8 dropped never starts", set_read_o, 0);
    chk("R8 ready again", early_ready_o, 1);
  endtask

  task automatic t_idle_pop();
    early_valid_i = 1; early_idx_i = 10'd6;
    tick(); early_valid_i = 0;
    full_valid_i = 1; full_idx_i = 10'd6; full_tag_i = 16'h0066; full_write_i = 0; settle();
    chk("R10 start idx", set_idx_o, 6);
    tick(); full_valid_i = 0; settle();
    chk("R11 busy", full_ready_o, 0);
    set_done_i = 1; settle();
    chk("R10 cmp", tag_cmp_o, 1);
    tick(); set_done_i = 0; settle();
    chk("R10 no second read", set_read_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_ni = 1;
    tick();
    t_reset();
    t_early_match();
    t_mismatch();
    t_write();
    t_queue();
    t_idle_pop();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule